// File: doc/BRIEF.md
# Temperature limit alarm comparator

This block holds a set of signed temperature limits and checks each fresh pair of readings against them. Channel 0 carries the local reading and channel 1 the remote reading. When a conversion-complete strobe arrives, the two readings are captured. On the following clock edge each reading is compared with its channel's upper and lower limit. Any violation sets a sticky status flag. Software reads and writes the limits, the status flags and a configuration register through a small synchronous register port.

An active-low alarm output is pulled low while any status flag is set, unless a mask bit in the configuration register holds it high. The flags stay set until the status register is read, so a brief excursion is never lost. Readings and limits are 8-bit two's-complement whole degrees, and every comparison is signed. A limit may therefore be negative even though real readings stay within 0 to 127.

Register map (index on `reg_addr`):
- 0: local upper limit
- 1: local lower limit
- 2: remote upper limit
- 3: remote lower limit
- 4 and 5: spare limit storage, read/write only
- 6: status, read clears
- 7: configuration, with bit 7 as the alarm mask

Top module: `thermal_limit_watch`

## Requirements
- R1: After reset the status flags are 0, `alert_n` is 1, the mask bit is 0, even-index limit registers hold 0x7F and odd-index ones hold 0x80.
- R2: A write to index 0..5 stores `reg_wdata`; a read returns the stored value on `reg_rdata` one clock after the read request, and `reg_rdata` holds its value when no read is requested.
- R3: Status bit 0 (local) or bit 2 (remote) sets when the captured reading is strictly greater than that channel's upper limit; equality does not set it.
- R4: Status bit 1 (local) or bit 3 (remote) sets when the captured reading is strictly less than that channel's lower limit; equality does not set it.
- R5: Limits and readings compare as signed two's-complement values, so negative limits (for example 0xFB = -5) work.
- R6: Flags change only on the second rising edge after `conv_done` is sampled high. Changing limits or readings without a strobe leaves the flags unchanged.
- R7: Flags are sticky across non-violating conversions. A read of index 6 returns the flags and clears them. A violation landing on the same edge as the clearing read stays set.
- R8: `alert_n` is 0 exactly when some flag is set and configuration bit 7 is 0. Writing 1 to that bit forces `alert_n` to 1 without touching the flags, and index 7 reads back the mask in bit 7 with other bits 0.
- R9: Writes to index 6 are ignored, and the values in indices 4 and 5 never affect the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Conversion-complete strobe; captures `reading_i` |
| reading_i | input | 2x8 | Signed readings, element 0 local, element 1 remote |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after `reg_rd` |
| status_o | output | 4 | Sticky flags: local upper, local lower, remote upper, remote lower |
| alert_n | output | 1 | Active-low alarm |

## Verification
The hardest case to reach is a violation whose compare edge coincides with the clearing status read. The bench gets there by raising the status read on the exact cycle after the strobe, so that both land on the same edge. It then checks two things: the read returns the old flags, and the new flag survives. Signed boundary behaviour is covered by sweeping one reading through all 256 codes against limits on both sides of zero. Each result is checked for exact flag values, the alarm level and clear-on-read.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    // Kind of register selected by an index on the register port
    typedef enum logic [1:0] {
        ACC_LIMIT  = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_CONFIG = 2'd2,
        ACC_NONE   = 2'd3
    } acc_kind_e;

    // Limits occupy 0..num_lim-1, then status, then configuration
    function automatic acc_kind_e classify(input int unsigned idx,
                                           input int unsigned num_lim);
        if (idx < num_lim)
            return ACC_LIMIT;
        else if (idx == num_lim)
            return ACC_STATUS;
        else if (idx == num_lim + 1)
            return ACC_CONFIG;
        else
            return ACC_NONE;
    endfunction

endpackage

// File: rtl/tlw_limit_regs.sv
module tlw_limit_regs #(
    parameter int TEMP_W  = 8,
    parameter int NUM_LIM = 6,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [TEMP_W-1:0]                wr_data,
    output logic [NUM_LIM-1:0][TEMP_W-1:0]   limits_o
);

    localparam logic [TEMP_W-1:0] UPPER_RST = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [TEMP_W-1:0] LOWER_RST = {1'b1, {(TEMP_W-1){1'b0}}};

    typedef struct packed {
        logic [NUM_LIM-1:0][TEMP_W-1:0] lim;
    } lim_state_t;

    lim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_LIM; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i)))
                st_d.lim[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LIM; i++)
                st_q.lim[i] <= ((i % 2) == 0) ? UPPER_RST : LOWER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign limits_o = st_q.lim;

endmodule

// File: rtl/tlw_channel_cmp.sv
module tlw_channel_cmp #(
    parameter int TEMP_W = 8
) (
    input  logic              valid_i,
    input  logic [TEMP_W-1:0] sample_i,
    input  logic [TEMP_W-1:0] upper_i,
    input  logic [TEMP_W-1:0] lower_i,
    output logic              over_o,
    output logic              under_o
);

    logic signed [TEMP_W-1:0] s_val, s_up, s_lo;

    always_comb begin
        s_val   = $signed(sample_i);
        s_up    = $signed(upper_i);
        s_lo    = $signed(lower_i);
        // strict comparisons: equality never trips
        over_o  = valid_i && (s_val > s_up);
        under_o = valid_i && (s_val < s_lo);
    end

endmodule

// File: rtl/tlw_flag_latch.sv
module tlw_flag_latch #(
    parameter int NUM_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 clr_i,
    output logic [NUM_FLAGS-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.flags = '0;
        // a set arriving with the clear wins
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/thermal_limit_watch.sv
module thermal_limit_watch
    import tlw_pkg::*;
#(
    parameter  int TEMP_W    = 8,
    parameter  int NUM_CH    = 2,
    parameter  int NUM_AUX   = 2,
    localparam int NUM_FLAGS = 2 * NUM_CH,
    localparam int NUM_LIM   = 2 * NUM_CH + NUM_AUX,
    localparam int ADDR_W    = $clog2(NUM_LIM + 2)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           conv_done,
    input  logic [NUM_CH-1:0][TEMP_W-1:0]  reading_i,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [TEMP_W-1:0]              reg_wdata,
    output logic [TEMP_W-1:0]              reg_rdata,
    output logic [NUM_FLAGS-1:0]           status_o,
    output logic                           alert_n
);

    typedef struct packed {
        logic                          pending;
        logic [NUM_CH-1:0][TEMP_W-1:0] sample;
        logic [TEMP_W-1:0]             rdata;
        logic                          mask;
    } top_state_t;

    top_state_t st_d, st_q;

    acc_kind_e                      kind;
    logic [NUM_LIM-1:0][TEMP_W-1:0] limits;
    logic [TEMP_W-1:0]              lim_sel;
    logic [NUM_FLAGS-1:0]           trip;
    logic [NUM_FLAGS-1:0]           flags;
    logic                           status_clr;
    logic                           cmp_pending;
    logic                           cfg_mask;

    assign kind        = classify(int'(reg_addr), NUM_LIM);
    assign status_clr  = reg_rd && (kind == ACC_STATUS);
    assign cmp_pending = st_q.pending;
    assign cfg_mask    = st_q.mask;

    tlw_limit_regs #(
        .TEMP_W  (TEMP_W),
        .NUM_LIM (NUM_LIM),
        .IDX_W   (ADDR_W)
    ) limits_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && (kind == ACC_LIMIT)),
        .wr_idx   (reg_addr),
        .wr_data  (reg_wdata),
        .limits_o (limits)
    );

    // one comparator per channel: upper at 2c, lower at 2c+1
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tlw_channel_cmp #(
            .TEMP_W (TEMP_W)
        ) cmp_i (
            .valid_i  (cmp_pending),
            .sample_i (st_q.sample[c]),
            .upper_i  (limits[2*c]),
            .lower_i  (limits[2*c+1]),
            .over_o   (trip[2*c]),
            .under_o  (trip[2*c+1])
        );
    end

    tlw_flag_latch #(
        .NUM_FLAGS (NUM_FLAGS)
    ) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (trip),
        .clr_i   (status_clr),
        .flags_o (flags)
    );

    always_comb begin
        lim_sel = '0;
        for (int i = 0; i < NUM_LIM; i++) begin
            if (reg_addr == ADDR_W'(i))
                lim_sel = limits[i];
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.pending = conv_done;
        if (conv_done)
            st_d.sample = reading_i;
        if (reg_wr && (kind == ACC_CONFIG))
            st_d.mask = reg_wdata[TEMP_W-1];
        if (reg_rd) begin
            unique case (kind)
                ACC_LIMIT:  st_d.rdata = lim_sel;
                ACC_STATUS: st_d.rdata = {{(TEMP_W-NUM_FLAGS){1'b0}}, flags};
                ACC_CONFIG: st_d.rdata = {st_q.mask, {(TEMP_W-1){1'b0}}};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign status_o  = flags;
    assign alert_n   = ~((|flags) & ~cfg_mask);

endmodule

// File: rtl/tlw_checker.sv
module tlw_checker #(
    parameter int TEMP_W      = 8,
    parameter int NUM_FLAGS   = 4,
    parameter int ADDR_W      = 3,
    parameter int STATUS_ADDR = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 conv_done,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [TEMP_W-1:0]    reg_rdata,
    input logic [NUM_FLAGS-1:0] status_o,
    input logic                 alert_n,
    input logic                 cmp_pending,
    input logic                 cfg_mask
);

    logic clr_req;
    assign clr_req = reg_rd && (reg_addr == ADDR_W'(STATUS_ADDR));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_o == '0) && alert_n);

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> $stable(reg_rdata));

    // R6
    strobe_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> cmp_pending);

    // R6
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cmp_pending) && !$past(clr_req)) |-> $stable(status_o));

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_req) |-> ((status_o & $past(status_o)) == $past(status_o)));

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mask |-> alert_n);

endmodule

bind thermal_limit_watch tlw_checker #(
    .TEMP_W      (TEMP_W),
    .NUM_FLAGS   (NUM_FLAGS),
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (NUM_LIM)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .status_o    (status_o),
    .alert_n     (alert_n),
    .cmp_pending (cmp_pending),
    .cfg_mask    (cfg_mask)
);

// File: tb/thermal_limit_watch_tb.sv
module thermal_limit_watch_tb_top;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            conv_done;
    logic [1:0][7:0] reading;
    logic            reg_wr;
    logic            reg_rd;
    logic [2:0]      reg_addr;
    logic [7:0]      reg_wdata;
    logic [7:0]      reg_rdata;
    logic [3:0]      status_o;
    logic            alert_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_limit_watch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .reading_i (reading),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_o  (status_o),
        .alert_n   (alert_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(idx); reg_wdata = 8'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output int data);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(idx);
        @(negedge clk);
        reg_rd = 1'b0;
        data = int'(reg_rdata);
    endtask

    // strobe, then wait for capture edge and compare edge
    task automatic conv(input int loc, input int rem);
        @(negedge clk);
        conv_done = 1'b1; reading[0] = 8'(loc); reading[1] = 8'(rem);
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
    endtask

    function automatic int expect_flags(int loc, int rem,
                                        int lh, int ll, int rh, int rl);
        int f = 0;
        if (loc > lh) f |= 1;
        if (loc < ll) f |= 2;
        if (rem > rh) f |= 4;
        if (rem < rl) f |= 8;
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int v;
        rst_n = 1'b0; conv_done = 1'b0; reading = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", int'(status_o), 0);
        check("R1 alert_n", int'(alert_n), 1);
        for (int i = 0; i < 6; i++) begin
            rd(i, v);
            check("R1 limit reset", v, (i % 2 == 0) ? 8'h7F : 8'h80);
        end
        rd(7, v);
        check("R1 config reset", v, 0);

        // R2 write and read back every limit index, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 6; i++)
                wr(i, (i * 37 + 5 + p * 101) & 8'hFF);
            for (int i = 0; i < 6; i++) begin
                rd(i, v);
                check("R2 readback", v, (i * 37 + 5 + p * 101) & 8'hFF);
            end
        end

        // R9 spare storage at extremes, status write ignored
        wr(4, 8'h80);
        wr(5, 8'h7F);
        wr(0, 80); wr(1, 10); wr(2, 8'hFB); wr(3, 8'hD8);
        wr(6, 8'hFF);
        check("R9 status write ignored", int'(status_o), 0);
        check("R9 alert after status write", int'(alert_n), 1);

        // R6 readings and limits change without a strobe
        @(negedge clk);
        reading[0] = 8'd127; reading[1] = 8'h80;
        wr(0, 8'h80);
        repeat (3) @(negedge clk);
        check("R6 no strobe no flag", int'(status_o), 0);
        wr(0, 80);
        // R6 flags unchanged at the capture edge, set at the next
        @(negedge clk);
        conv_done = 1'b1; reading[0] = 8'd100; reading[1] = 8'd0;
        @(negedge clk);
        conv_done = 1'b0;
        check("R6 capture edge", int'(status_o), 0);
        @(negedge clk);
        check("R6 compare edge", int'(status_o), 5);
        rd(6, v);
        check("R7 read returns flags", v, 5);

        // R3 R4 R5 signed sweep of both channels over every code
        for (int s = -128; s < 128; s++) begin
            int e;
            e = expect_flags(s, s, 80, 10, -5, -40);
            conv(s, s);
            check("R3 R4 R5 sweep flags", int'(status_o), e);
            check("R8 sweep alert", int'(alert_n), (e != 0) ? 0 : 1);
            rd(6, v);
            check("R7 sweep read", v, e);
            check("R7 sweep cleared", int'(status_o), 0);
        end

        // R7 sticky across a quiet conversion
        conv(100, 0);
        check("R7 first violation", int'(status_o), 5);
        conv(50, -10);
        check("R7 sticky", int'(status_o), 5);
        rd(6, v);
        check("R7 read value", v, 5);
        check("R7 cleared", int'(status_o), 0);

        // R7 clearing read on the compare edge
        @(negedge clk);
        conv_done = 1'b1; reading[0] = 8'd100; reading[1] = 8'hCE;
        @(negedge clk);
        conv_done = 1'b0;
        reg_rd = 1'b1; reg_addr = 3'd6;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R7 same edge read value", int'(reg_rdata), 0);
        check("R7 same edge set wins", int'(status_o), 9);

        // R8 mask behaviour
        check("R8 alert asserted", int'(alert_n), 0);
        wr(7, 8'h80);
        check("R8 masked alert", int'(alert_n), 1);
        check("R8 flags kept under mask", int'(status_o), 9);
        rd(7, v);
        check("R8 config readback", v, 8'h80);
        wr(7, 8'h7F);
        check("R8 unmasked alert", int'(alert_n), 0);
        rd(7, v);
        check("R8 config cleared", v, 0);
        rd(6, v);
        check("R8 alert after clear", int'(alert_n), 1);

        // R9 spare limits did not trip with extreme readings in range
        conv(60, -20);
        check("R9 spare no effect", int'(status_o), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule